// File: doc/BRIEF.md
# Frozen-Shadow BCD Calendar Clock

This block is a calendar clock that counts a 100 Hz strobe. It keeps hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year, all in BCD. It holds two copies of that time. The running copy advances on every enabled strobe and cannot be seen directly. The visible copy is what a host reads and writes over a small synchronous byte port. The host can freeze the visible copy, read or rewrite it at leisure, and then release it. The running copy does not stop while the visible copy is frozen, so the clock loses no time.

When the host wrote time fields during a freeze, releasing the freeze loads the whole visible copy into the running copy. The clock then runs on from the values the host wrote, hundredths included. An oscillator-stop bit halts all counting. Hours run in either 24-hour or 12-hour form, and the date wraps at the correct length of each month, with 29 days in February of leap years.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset the visible fields read hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, and the control byte reads 0x80 (transfer on, oscillator running).
- R2: Map: 0x0 hundredths, 0x1 seconds, 0x2 minutes, 0x4 hours, 0x6 day, 0x8 date, 0x9 month, 0xA year, 0xB control. A read presents its byte on `bus_rdata` one cycle after the read cycle. Unimplemented bits read 0, whatever was written. The implemented bits are: seconds and minutes [6:0], hours [6:0], day [2:0], date [5:0], month [4:0] plus bit 7, hundredths and year [7:0].
- R3: Each enabled strobe advances hundredths by one in BCD. From 0x99 it rolls to 0x00 and carries into seconds.
- R4: Seconds and minutes count 00 to 59 and carry into the next field when they wrap.
- R5: With control bit 7 (transfer) at 1, every enabled strobe loads the whole visible copy in the same cycle with the advanced running time. Strobes counted while frozen therefore show up after release.
- R6: With transfer at 0, the visible copy changes only through host writes, while the running copy keeps counting.
- R7: Suppose time fields were written while transfer was 0. The write that sets transfer back to 1 then copies the entire visible copy into the running copy, and no advance is applied in that cycle, even if a strobe arrives. Counting resumes from the written hundredths.
- R8: Month bit 7 set to 1 stops the oscillator: strobes are ignored and both copies hold. The bit reads back at month bit 7.
- R9: Hours bit 6 = 1 selects 12-hour form, with bit 5 = PM and hours 01 to 12. 11 AM goes to 12 PM with no day carry, 11 PM goes to 12 AM with a day carry, and 12 goes to 01.
- R10: In 24-hour form (bit 6 = 0) hours count 00 to 23, and bit 5 is the tens digit for 20 to 23. Wrapping from 23 carries into day and date. Day counts 1 to 7 and wraps to 1.
- R11: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months. February wraps after 28, or after 29 when the BCD year is divisible by 4 (00 counts as a leap year).
- R12: After the date wraps, month goes from 12 to 01 with a year carry. Year counts BCD 00 to 99 and wraps to 00.
- R13: Reads of unmapped addresses (0x3, 0x5, 0x7, 0xC to 0xF) return 0x00, and writes to them change nothing. The control byte reads only bit 7, with bits 6:0 at 0.
- R14: A host write to a time field in the same cycle as an enabled strobe, with transfer at 1, puts the written value into that field of both copies. All other fields advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz strobe |
| bus_sel | input | 1 | Access strobe for the byte port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |

## Verification
A host write and a strobe can land in the same clock edge, and two cases matter. In the first, a time field is written while a strobe advances the clock. The bench drives both on one edge, reads the field back, and then sends one more strobe. This proves that the written value is in both copies and was not overwritten by the increment. In the second, the release write that restores the running copy coincides with a strobe. That case is judged by the hundredths value after a further strobe: it must be one above the frozen value, not two.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
package rtc_shadow_pkg;
  localparam int NF   = 8;             // number of time fields
  localparam int FW   = 8;             // bits per field
  localparam int AW   = 4;             // register address width
  localparam int FIW  = $clog2(NF);

  typedef logic [NF-1:0][FW-1:0] tvec_t;

  localparam int FI_HUND = 0;
  localparam int FI_SEC  = 1;
  localparam int FI_MIN  = 2;
  localparam int FI_HOUR = 3;
  localparam int FI_DAY  = 4;
  localparam int FI_DATE = 5;
  localparam int FI_MON  = 6;
  localparam int FI_YEAR = 7;

  localparam logic [AW-1:0] CTRL_ADDR = 4'hB;

  // year, month, date, day, hour, minute, second, hundredths
  localparam tvec_t RST_T = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [FW-1:0] y);
    logic [7:0] bin;
    bin = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return (bin & 8'h03) == 8'h00;
  endfunction

  function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                               input logic [FW-1:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // returns {day_carry, next_hour}
  function automatic logic [FW:0] hour_step(input logic [FW-1:0] h);
    logic [FW-1:0] v;
    logic pm;
    logic c;
    if (h[6]) begin
      pm = h[5];
      v  = {3'b000, h[4:0]};
      c  = 1'b0;
      if (v == 8'h11) begin
        v  = 8'h12;
        c  = pm;
        pm = ~pm;
      end else if (v >= 8'h12) begin
        v = 8'h01;
      end else begin
        v = bcd_inc(v);
      end
      return {c, 1'b0, 1'b1, pm, v[4:0]};
    end
    v = {2'b00, h[5:0]};
    if (v >= 8'h23) return {1'b1, 8'h00};
    return {1'b0, bcd_inc(v)};
  endfunction

  function automatic logic [FW-1:0] field_mask(input int idx);
    case (idx)
      FI_HUND, FI_YEAR:        return 8'hFF;
      FI_SEC, FI_MIN, FI_HOUR: return 8'h7F;
      FI_DAY:                  return 8'h07;
      FI_DATE:                 return 8'h3F;
      FI_MON:                  return 8'h1F;
      default:                 return 8'h00;
    endcase
  endfunction

  // field index for an address, -1 when the address holds no time field
  function automatic int addr_field(input logic [AW-1:0] a);
    case (a)
      4'h0:    return FI_HUND;
      4'h1:    return FI_SEC;
      4'h2:    return FI_MIN;
      4'h4:    return FI_HOUR;
      4'h6:    return FI_DAY;
      4'h8:    return FI_DATE;
      4'h9:    return FI_MON;
      4'hA:    return FI_YEAR;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_advance.sv
`timescale 1ns/1ps
module rtc_tick_advance
  import rtc_shadow_pkg::*;
(
  input  tvec_t cur,
  output tvec_t nxt,
  output logic  roll_evt,
  output logic  min_carry,
  output logic  day_carry,
  output logic  year_carry
);
  logic          sec_carry;
  logic          date_carry;
  logic [FW:0]   hr_step;

  assign hr_step = hour_step(cur[FI_HOUR]);

  always_comb begin
    nxt        = cur;
    roll_evt   = (cur[FI_HUND] == 8'h99);
    sec_carry  = roll_evt && (cur[FI_SEC] >= 8'h59);
    min_carry  = sec_carry && (cur[FI_MIN] >= 8'h59);
    day_carry  = min_carry && hr_step[FW];
    date_carry = day_carry && (cur[FI_DATE] >= month_days(cur[FI_MON], cur[FI_YEAR]));
    year_carry = date_carry && (cur[FI_MON] >= 8'h12);

    nxt[FI_HUND] = roll_evt ? 8'h00 : bcd_inc(cur[FI_HUND]);
    if (roll_evt)  nxt[FI_SEC]  = sec_carry ? 8'h00 : bcd_inc(cur[FI_SEC]);
    if (sec_carry) nxt[FI_MIN]  = min_carry ? 8'h00 : bcd_inc(cur[FI_MIN]);
    if (min_carry) nxt[FI_HOUR] = hr_step[FW-1:0];
    if (day_carry) begin
      nxt[FI_DAY]  = (cur[FI_DAY] >= 8'h07) ? 8'h01 : cur[FI_DAY] + 8'h01;
      nxt[FI_DATE] = date_carry ? 8'h01 : bcd_inc(cur[FI_DATE]);
    end
    if (date_carry) nxt[FI_MON] = year_carry ? 8'h01 : bcd_inc(cur[FI_MON]);
    if (year_carry) nxt[FI_YEAR] = (cur[FI_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cur[FI_YEAR]);
  end
endmodule

// File: rtl/rtc_internal_count.sv
`timescale 1ns/1ps
module rtc_internal_count
  import rtc_shadow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  tvec_t         nxt,
  input  logic          roll_evt,
  input  logic          min_carry,
  input  logic          day_carry,
  input  logic          year_carry,
  input  logic          load_all,
  input  tvec_t         load_val,
  input  logic [NF-1:0] fld_we,
  input  logic [FW-1:0] fld_val,
  output tvec_t         cur
);
  logic quiet;
  assign quiet = !load_all && (fld_we == '0);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= RST_T[g];
      else if (load_all)   q <= load_val[g];
      else if (fld_we[g])  q <= fld_val;
      else if (step)       q <= nxt[g];
    end
    assign cur[g] = q;
  end

  AST_HUND_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && roll_evt) |=> cur[FI_HUND] == 8'h00); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && roll_evt && cur[FI_SEC] == 8'h59) |=> cur[FI_SEC] == 8'h00); // R4
  AST_NOON_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && min_carry && cur[FI_HOUR] == 8'h51) |=> (cur[FI_HOUR] == 8'h72 && $stable(cur[FI_DAY]))); // R9
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && day_carry && cur[FI_DAY] == 8'h07) |=> cur[FI_DAY] == 8'h01); // R10
  AST_DATE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && day_carry && cur[FI_DATE] == 8'h31) |=> cur[FI_DATE] == 8'h01); // R11
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && quiet && year_carry && cur[FI_YEAR] == 8'h99) |=> cur[FI_YEAR] == 8'h00); // R12
endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
module rtc_shadow_bank
  import rtc_shadow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [FW-1:0] bus_wdata,
  input  logic          step,
  input  tvec_t         int_nxt,
  output tvec_t         ext,
  output logic          te,
  output logic          osc_off,
  output logic          restore,
  output logic [NF-1:0] int_fld_we,
  output logic [FW-1:0] fld_val,
  output logic [FW-1:0] bus_rdata
);
  logic          host_wr;
  logic          host_rd;
  logic          ctrl_wr;
  int            fidx;
  logic [NF-1:0] wr_hit;
  logic          pend_q;
  logic [FW-1:0] rd_mux;

  assign host_wr = bus_sel && bus_we;
  assign host_rd = bus_sel && !bus_we;
  assign ctrl_wr = host_wr && (bus_addr == CTRL_ADDR);
  assign fidx    = addr_field(bus_addr);
  assign fld_val = bus_wdata & field_mask(fidx);

  for (genvar g = 0; g < NF; g++) begin : g_hit
    assign wr_hit[g] = host_wr && (fidx == g);
  end

  assign int_fld_we = te ? wr_hit : '0;
  assign restore    = ctrl_wr && bus_wdata[7] && !te && pend_q;

  for (genvar g = 0; g < NF; g++) begin : g_ext
    logic [FW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= RST_T[g];
      else if (wr_hit[g])    q <= fld_val;
      else if (step && te)   q <= int_nxt[g];
    end
    assign ext[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te      <= 1'b1;
      osc_off <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (ctrl_wr)          te      <= bus_wdata[7];
      if (wr_hit[FI_MON])   osc_off <= bus_wdata[7];
      if (restore)          pend_q  <= 1'b0;
      else if (!te && (wr_hit != '0)) pend_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == CTRL_ADDR)  rd_mux = {te, 7'b0};
    else if (fidx == FI_MON)    rd_mux = {osc_off, ext[FI_MON][6:0]};
    else if (fidx >= 0)         rd_mux = ext[fidx[FIW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= 8'h00;
    else if (host_rd) bus_rdata <= rd_mux;
  end

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ext[FI_SEC][7] == 1'b0 && ext[FI_MIN][7] == 1'b0 && ext[FI_HOUR][7] == 1'b0 &&
     ext[FI_DAY][7:3] == 5'd0 && ext[FI_DATE][7:6] == 2'd0 && ext[FI_MON][7:5] == 3'd0)); // R2
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && bus_addr == CTRL_ADDR) |=> bus_rdata[6:0] == 7'd0); // R13
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fidx < 0 && bus_addr != CTRL_ADDR) |=> bus_rdata == 8'h00); // R13
endmodule

// File: rtl/rtc_shadow_clock.sv
`timescale 1ns/1ps
module rtc_shadow_clock
  import rtc_shadow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [FW-1:0] bus_wdata,
  output logic [FW-1:0] bus_rdata
);
  tvec_t         int_v;
  tvec_t         int_nxt;
  tvec_t         ext_v;
  logic          roll_evt;
  logic          min_carry;
  logic          day_carry;
  logic          year_carry;
  logic          te;
  logic          osc_off;
  logic          restore;
  logic          step;
  logic          host_wr;
  logic [NF-1:0] int_fld_we;
  logic [FW-1:0] fld_val;

  assign step    = tick && !osc_off;
  assign host_wr = bus_sel && bus_we;

  rtc_tick_advance i_adv (
    .cur        (int_v),
    .nxt        (int_nxt),
    .roll_evt   (roll_evt),
    .min_carry  (min_carry),
    .day_carry  (day_carry),
    .year_carry (year_carry)
  );

  rtc_internal_count i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .nxt        (int_nxt),
    .roll_evt   (roll_evt),
    .min_carry  (min_carry),
    .day_carry  (day_carry),
    .year_carry (year_carry),
    .load_all   (restore),
    .load_val   (ext_v),
    .fld_we     (int_fld_we),
    .fld_val    (fld_val),
    .cur        (int_v)
  );

  rtc_shadow_bank i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .step       (step),
    .int_nxt    (int_nxt),
    .ext        (ext_v),
    .te         (te),
    .osc_off    (osc_off),
    .restore    (restore),
    .int_fld_we (int_fld_we),
    .fld_val    (fld_val),
    .bus_rdata  (bus_rdata)
  );

  AST_SHADOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (te && step && !host_wr) |=> ext_v == int_v); // R5
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !host_wr) |=> $stable(ext_v)); // R6
  AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> int_v == $past(ext_v)); // R7
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !host_wr) |=> $stable(int_v)); // R8
  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && te && step && bus_addr == 4'h1) |=>
      (int_v[FI_SEC] == {1'b0, $past(bus_wdata[6:0])} && ext_v[FI_SEC] == int_v[FI_SEC])); // R14
endmodule

// File: tb/test_rtc_shadow_clock.sv
`timescale 1ns/1ps
module test_rtc_shadow_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sel = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_shadow_clock i_rtc_shadow_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  // byte order: year, month, date, day, hour, minute, second, hundredths
  // entry: {preset, expected, strobes, requirement number}
  localparam int NV = 16;
  localparam logic [143:0] VECS [NV] = '{
    {64'h00_01_01_01_00_00_00_00, 64'h00_01_01_01_00_00_00_05, 8'd5, 8'd3},  // R3
    {64'h99_12_31_07_23_59_59_99, 64'h00_01_01_01_00_00_00_00, 8'd1, 8'd12}, // R12 R10
    {64'h23_06_15_03_09_14_59_99, 64'h23_06_15_03_09_15_00_00, 8'd1, 8'd4},  // R4
    {64'h24_02_28_04_23_59_59_99, 64'h24_02_29_05_00_00_00_00, 8'd1, 8'd11}, // R11
    {64'h23_02_28_04_23_59_59_99, 64'h23_03_01_05_00_00_00_00, 8'd1, 8'd11}, // R11
    {64'h00_02_29_02_23_59_59_99, 64'h00_03_01_03_00_00_00_00, 8'd1, 8'd11}, // R11
    {64'h05_04_30_06_23_59_59_99, 64'h05_05_01_07_00_00_00_00, 8'd1, 8'd11}, // R11
    {64'h05_01_30_07_23_59_59_99, 64'h05_01_31_01_00_00_00_00, 8'd1, 8'd10}, // R10
    {64'h10_03_10_02_51_59_59_99, 64'h10_03_10_02_72_00_00_00, 8'd1, 8'd9},  // R9
    {64'h10_03_10_03_71_59_59_99, 64'h10_03_11_04_52_00_00_00, 8'd1, 8'd9},  // R9
    {64'h10_03_10_03_52_59_59_99, 64'h10_03_10_03_41_00_00_00, 8'd1, 8'd9},  // R9
    {64'h10_03_10_03_19_59_59_99, 64'h10_03_10_03_20_00_00_00, 8'd1, 8'd10}, // R10
    {64'h10_09_30_03_23_59_59_99, 64'h10_10_01_04_00_00_00_00, 8'd1, 8'd11}, // R11
    {64'h10_03_10_03_10_20_30_09, 64'h10_03_10_03_10_20_30_10, 8'd1, 8'd3},  // R3
    {64'h19_12_31_05_23_59_59_99, 64'h20_01_01_06_00_00_00_00, 8'd1, 8'd12}, // R12
    {64'h10_03_10_03_69_59_59_99, 64'h10_03_10_03_70_00_00_00, 8'd1, 8'd9}   // R9
  };

  // address of byte k (k = 0 hundredths ... 7 year)
  function automatic logic [3:0] fld_addr(input int k);
    case (k)
      0: return 4'h0; 1: return 4'h1; 2: return 4'h2; 3: return 4'h4;
      4: return 4'h6; 5: return 4'h8; 6: return 4'h9; default: return 4'hA;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic strobe();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wr_with_strobe(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick = 1'b1;
    @(negedge clk); sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(4'hB, 8'h00);
    for (int k = 0; k < 8; k++) wr(fld_addr(k), t[k*8 +: 8]);
    wr(4'hB, 8'h80);
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 hundredths", 4'h0, 8'h00);
    expect_reg("R1 seconds",    4'h1, 8'h00);
    expect_reg("R1 minutes",    4'h2, 8'h00);
    expect_reg("R1 hours",      4'h4, 8'h00);
    expect_reg("R1 day",        4'h6, 8'h01);
    expect_reg("R1 date",       4'h8, 8'h01);
    expect_reg("R1 month",      4'h9, 8'h01);
    expect_reg("R1 year",       4'hA, 8'h00);
    expect_reg("R1 control",    4'hB, 8'h80);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [63:0] pre;
      logic [63:0] exp;
      string tag;
      pre = VECS[i][143:80];
      exp = VECS[i][79:16];
      tag = $sformatf("R%0d vector %0d", VECS[i][7:0], i);
      set_time(pre);
      for (int n = 0; n < int'(VECS[i][15:8]); n++) strobe();
      for (int k = 0; k < 8; k++) expect_reg(tag, fld_addr(k), exp[k*8 +: 8]);
    end

    // R2 unimplemented bits read zero
    set_time(64'h10_03_10_03_10_20_30_40);
    wr(4'h1, 8'hC5); expect_reg("R2 seconds mask", 4'h1, 8'h45);
    wr(4'h2, 8'hB3); expect_reg("R2 minutes mask", 4'h2, 8'h33);
    wr(4'h4, 8'h9A); expect_reg("R2 hours mask",   4'h4, 8'h1A);
    wr(4'h6, 8'hFE); expect_reg("R2 day mask",     4'h6, 8'h06);
    wr(4'h8, 8'hE7); expect_reg("R2 date mask",    4'h8, 8'h27);
    wr(4'h9, 8'h6A); expect_reg("R2 month mask",   4'h9, 8'h0A);

    // R6 / R5 freeze without writes, then release
    set_time(64'h10_03_10_03_10_20_30_40);
    wr(4'hB, 8'h00);
    repeat (3) strobe();
    expect_reg("R6 frozen hundredths", 4'h0, 8'h40);
    wr(4'hB, 8'h80);
    expect_reg("R6 released before strobe", 4'h0, 8'h40);
    strobe();
    expect_reg("R5 no time lost", 4'h0, 8'h44);

    // R7 write during freeze is restored into running copy
    wr(4'hB, 8'h00);
    repeat (2) strobe();
    wr(4'h2, 8'h33);
    wr(4'hB, 8'h80);
    expect_reg("R7 restored minutes", 4'h2, 8'h33);
    expect_reg("R7 restored hundredths", 4'h0, 8'h44);
    strobe();
    expect_reg("R7 restart from written", 4'h0, 8'h45);
    expect_reg("R7 minutes kept", 4'h2, 8'h33);

    // R7 release coinciding with a strobe: copy wins, no advance
    wr(4'hB, 8'h00);
    repeat (2) strobe();
    wr(4'h1, 8'h05);
    wr_with_strobe(4'hB, 8'h80);
    expect_reg("R7 release+strobe hundredths", 4'h0, 8'h45);
    strobe();
    expect_reg("R7 one advance after release", 4'h0, 8'h46);
    expect_reg("R7 seconds restored", 4'h1, 8'h05);

    // R14 field write in the same cycle as a strobe
    set_time(64'h10_03_10_03_10_20_10_99);
    wr_with_strobe(4'h1, 8'hC2);
    expect_reg("R14 written seconds", 4'h1, 8'h42);
    expect_reg("R14 hundredths advanced", 4'h0, 8'h00);
    expect_reg("R14 minutes untouched", 4'h2, 8'h20);
    strobe();
    expect_reg("R14 running copy holds write", 4'h1, 8'h42);
    expect_reg("R14 next hundredths", 4'h0, 8'h01);

    // R8 oscillator stop
    set_time(64'h10_03_10_03_10_20_30_50);
    wr(4'h9, 8'h83);
    repeat (3) strobe();
    expect_reg("R8 halted hundredths", 4'h0, 8'h50);
    expect_reg("R8 month reads stop bit", 4'h9, 8'h83);
    wr(4'h9, 8'h03);
    strobe();
    expect_reg("R8 running again", 4'h0, 8'h51);

    // R13 unmapped addresses and control readback
    wr(4'h3, 8'hFF);
    expect_reg("R13 addr 3", 4'h3, 8'h00);
    expect_reg("R13 addr 5", 4'h5, 8'h00);
    expect_reg("R13 addr 7", 4'h7, 8'h00);
    expect_reg("R13 addr C", 4'hC, 8'h00);
    expect_reg("R13 addr F", 4'hF, 8'h00);
    expect_reg("R13 hundredths untouched", 4'h0, 8'h51);
    wr(4'hB, 8'hFF);
    expect_reg("R13 control bit7 only", 4'hB, 8'h80);
    wr(4'hB, 8'h7F);
    expect_reg("R13 control cleared", 4'hB, 8'h00);
    wr(4'hB, 8'h80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule